// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a register interface and an external successive-approximation converter core. Software writes channel numbers into a four-entry command queue. The sequencer drives the core through a simple handshake: a channel select, a one-cycle start strobe, an end-of-conversion strobe with a 10-bit result, and a power-down line. Each finished result is stored with its channel number in a four-entry result queue. Software reads the queue through a status word, and every read removes the oldest entry.

All converter timing runs on a slow enable tick, which is derived from the input clock by a programmable divisor. When the channel changes, the sequencer waits a programmable number of ticks before it issues the next start, so the analog input can settle. The block has two modes. In single mode each command runs one conversion, and the core can optionally be put into power-down afterwards. In continuous mode conversions repeat on the current channel until a new command is queued. The interrupt line reports when the result queue holds more entries than a programmable threshold.

Top module: `adc_seq`

## Requirements
- R1: After reset, the configuration reads 0x2400 (divisor 2 in bits 15:12, settle 4 in bits 11:8, all other fields 0). The status word reads 0, and irq, adc_pd and adc_start are all 0.
- R2: A configuration write takes effect on the next cycle. Bit 7 (test-only) and bit 6 always read back as 0. The field layout is: 15:12 divisor, 11:8 settle ticks, 5:4 threshold, 3 interrupt enable, 2 truncate, 1 auto power-down, 0 single mode.
- R3: The command queue holds up to 4 channels and is served in write order. Its count is shown in status bits 30:28. A command write made while the queue is full is dropped.
- R4: The result queue holds up to 4 entries. Its count is in status bits 26:24, the head channel in bits 18:16 and the head result in bits 9:0. A status read pops the head entry. When the queue is empty, the channel and result fields read 0. A result that finishes while the queue is full is discarded.
- R5: Start strobes fall only on converter ticks, which repeat every (divisor+1)*2 input clocks. Each start strobe lasts one cycle.
- R6: When a new command carries a channel different from the current select, the next start is delayed by exactly (settle ticks) converter ticks. A command with the same channel adds no delay.
- R7: In single mode (bit 0 = 1), each command produces exactly one start and one result.
- R8: In continuous mode (bit 0 = 0), conversions repeat on the current channel without further commands. Conversions keep running while the result queue is full, and their results are dropped.
- R9: irq is 1 exactly when interrupt enable (bit 3) is 1 and the result count is strictly greater than the threshold (bits 5:4).
- R10: When truncate (bit 2) is 1, status bits 9:0 show the head result shifted right by two. The stored entry is not changed.
- R11: With single mode and auto power-down both set, adc_pd rises when a conversion completes. It falls when the next command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Current configuration |
| cmd_we | input | 1 | Command queue write strobe |
| cmd_chan | input | 3 | Channel to queue |
| stat_re | input | 1 | Status read strobe; pops the head result |
| stat_rdata | output | 32 | Status word (queue counts, head channel, head result) |
| irq | output | 1 | Result threshold interrupt |
| adc_sel | output | 3 | Channel select to the converter core |
| adc_start | output | 1 | One-cycle start-of-conversion strobe |
| adc_done | input | 1 | End-of-conversion strobe from the core |
| adc_data | input | 10 | Conversion result, valid with adc_done |
| adc_pd | output | 1 | Converter power-down request |

## Verification
The configuration and queue counts update on the clock edge that follows a write or a done strobe. The status word is combinational from that state, so the bench reads it at the next falling edge. Start strobes are timed by cycle stamps taken at falling edges. For each setting of divisor and settle ticks, the bench checks that the gap between two starts on one channel is a whole number of tick periods, and that a channel change adds exactly settle×(divisor+1)×2 cycles to that gap. Single-mode and queue-full checks wait for the results to arrive and then hold for a settling window, which shows that no extra start or entry appears afterwards.

// File: rtl/adc_seq.sv
module adc_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        cmd_we,
  input  logic [2:0]  cmd_chan,
  input  logic        stat_re,
  output logic [31:0] stat_rdata,
  output logic        irq,
  output logic [2:0]  adc_sel,
  output logic        adc_start,
  input  logic        adc_done,
  input  logic [9:0]  adc_data,
  output logic        adc_pd
);
  localparam int DEPTH = 4;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [15:0] CFG_RST = 16'h2400;
  localparam logic [15:0] CFG_MASK = 16'hFF3F;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_START, S_WAIT} st_t;

  logic [15:0] cfg;
  wire [3:0] f_div   = cfg[15:12];
  wire [3:0] f_dly   = cfg[11:8];
  wire [1:0] f_th    = cfg[5:4];
  wire       f_ie    = cfg[3];
  wire       f_trunc = cfg[2];
  wire       f_apd   = cfg[1];
  wire       f_sm    = cfg[0];

  always_ff @(posedge clk)
    if (!rst_n)      cfg <= CFG_RST;
    else if (cfg_we) cfg <= cfg_wdata & CFG_MASK;
  assign cfg_rdata = cfg;

  logic [4:0] div_cnt;
  wire  [4:0] div_lim = {f_div, 1'b1};
  wire        tick    = div_cnt >= div_lim;
  always_ff @(posedge clk)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? 5'd0 : div_cnt + 5'd1;

  st_t        state;
  logic [3:0] dly_cnt;
  logic [2:0] sel;

  logic [2:0]    cq [DEPTH];
  logic [PW-1:0] cq_wp, cq_rp;
  logic [CW-1:0] cq_cnt;
  wire  [2:0]    nxt_ch    = cq[cq_rp];
  wire           cq_nempty = cq_cnt != 0;
  wire           conv_done = (state == S_WAIT) && adc_done;
  wire cmd_push = cmd_we && (cq_cnt != CW'(DEPTH));
  wire cmd_pop  = ((state == S_IDLE) && tick && cq_nempty) ||
                  (conv_done && !f_sm && cq_nempty);
  wire need_settle = (nxt_ch != sel) && (f_dly != 4'd0);

  always_ff @(posedge clk)
    if (!rst_n) begin
      cq_wp <= '0; cq_rp <= '0; cq_cnt <= '0;
    end else begin
      if (cmd_push) begin
        cq[cq_wp] <= cmd_chan;
        cq_wp <= cq_wp + 1'b1;
      end
      if (cmd_pop) cq_rp <= cq_rp + 1'b1;
      cq_cnt <= cq_cnt + CW'(cmd_push) - CW'(cmd_pop);
    end

  logic [12:0]   rq [DEPTH];
  logic [PW-1:0] rq_wp, rq_rp;
  logic [CW-1:0] rq_cnt;
  wire res_push = conv_done && (rq_cnt != CW'(DEPTH));
  wire res_pop  = stat_re && (rq_cnt != 0);

  always_ff @(posedge clk)
    if (!rst_n) begin
      rq_wp <= '0; rq_rp <= '0; rq_cnt <= '0;
    end else begin
      if (res_push) begin
        rq[rq_wp] <= {sel, adc_data};
        rq_wp <= rq_wp + 1'b1;
      end
      if (res_pop) rq_rp <= rq_rp + 1'b1;
      rq_cnt <= rq_cnt + CW'(res_push) - CW'(res_pop);
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      state <= S_IDLE; dly_cnt <= '0; sel <= '0; adc_pd <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (cmd_pop) begin
            sel <= nxt_ch;
            adc_pd <= 1'b0;
            dly_cnt <= f_dly;
            state <= need_settle ? S_SETTLE : S_START;
          end
        S_SETTLE:
          if (tick) begin
            if (dly_cnt <= 4'd1) state <= S_START;
            else dly_cnt <= dly_cnt - 4'd1;
          end
        S_START:
          if (tick) state <= S_WAIT;
        default:
          if (adc_done) begin
            if (f_sm) begin
              state <= S_IDLE;
              adc_pd <= f_apd;
            end else if (cq_nempty) begin
              sel <= nxt_ch;
              dly_cnt <= f_dly;
              state <= need_settle ? S_SETTLE : S_START;
            end else begin
              state <= S_START;
            end
          end
      endcase
    end

  assign adc_start = (state == S_START) && tick;
  assign adc_sel   = sel;

  wire [12:0] head    = (rq_cnt != 0) ? rq[rq_rp] : 13'd0;
  wire [9:0]  head_dv = f_trunc ? {2'b00, head[9:2]} : head[9:0];
  assign stat_rdata = {1'b0, cq_cnt, 1'b0, rq_cnt, 5'd0, head[12:10], 6'd0, head_dv};
  assign irq = f_ie && (rq_cnt > {1'b0, f_th});

  // R3 R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_cnt <= CW'(DEPTH)) && (rq_cnt <= CW'(DEPTH)));
  // R3
  cmd_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cq_cnt == CW'(DEPTH)) |=> (cq_cnt == CW'(DEPTH) - CW'($past(cmd_pop))));
  // R4
  res_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_cnt <= $past(rq_cnt) + CW'(1));
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> $stable(adc_sel));
endmodule

// File: tb/tb_adc_seq.sv
`timescale 1ns/1ps
module tb_adc_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cmd_we = 0, stat_re = 0, adc_done = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic [2:0] cmd_chan = 0, adc_sel;
  logic [31:0] stat_rdata;
  logic irq, adc_start, adc_pd;
  logic [9:0] adc_data = 0;

  adc_seq dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0, nstarts = 0, n_chk = 0, n_fail = 0;
  logic stall = 0, busy = 0;
  int rcnt = 0;
  logic [2:0] rch = 0;

  function automatic logic [9:0] conv_val(input logic [2:0] ch);
    return 10'(ch * 100 + 7);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (busy && !stall) begin
      if (rcnt <= 1) begin
        adc_done <= 1'b1; adc_data <= conv_val(rch); busy = 0;
      end else rcnt = rcnt - 1;
    end
    if (adc_start) begin
      busy = 1; rcnt = 3; rch = adc_sel; nstarts = nstarts + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic post(input logic [2:0] ch);
    @(negedge clk); cmd_we = 1; cmd_chan = ch;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic pop(output logic [31:0] st);
    @(negedge clk); st = stat_rdata; stat_re = 1;
    @(negedge clk); stat_re = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_res(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (int'(stat_rdata[26:24]) >= n) return;
    end
  endtask

  task automatic wait_start(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (adc_start) begin t = cyc; return; end
    end
  endtask

  task automatic start_post(input logic [2:0] ch, output int t);
    wait_start(t);
    cmd_we = 1; cmd_chan = ch;
    @(negedge clk); cmd_we = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] st;
    int s0, t0, t1, t2, t3, t4, gap;
    idle(5);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 16'h2400, "R1 cfg", cfg_rdata, 16'h2400);
    chk(stat_rdata == 0 && !irq && !adc_pd && !adc_start, "R1 outputs", stat_rdata, 0);

    // R2
    wr_cfg(16'hFFFF);
    chk(cfg_rdata == 16'hFF3F, "R2 readback", cfg_rdata, 16'hFF3F);
    wr_cfg(16'h0101);

    // R7 and R4: single mode sweep over all channels
    for (int ch = 0; ch < 8; ch++) begin
      s0 = nstarts;
      post(3'(ch));
      wait_res(1);
      idle(60);
      chk(stat_rdata[26:24] == 1 && nstarts == s0 + 1, "R7 one per cmd", nstarts - s0, 1);
      chk(stat_rdata[18:16] == 3'(ch), "R4 head chan", stat_rdata[18:16], ch);
      chk(stat_rdata[9:0] == conv_val(3'(ch)), "R4 head data", stat_rdata[9:0], conv_val(3'(ch)));
      pop(st);
      chk(stat_rdata == 0, "R4 empty after pop", stat_rdata, 0);
    end

    // R10
    wr_cfg(16'h0105);
    post(5);
    wait_res(1);
    chk(stat_rdata[9:0] == 10'(507 >> 2), "R10 truncated", stat_rdata[9:0], 507 >> 2);
    chk(stat_rdata[18:16] == 5, "R10 chan intact", stat_rdata[18:16], 5);
    wr_cfg(16'h0101);
    chk(stat_rdata[9:0] == 507, "R10 stored unchanged", stat_rdata[9:0], 507);
    pop(st);

    // R3, R4 full discard, R9
    wr_cfg(16'h0139);
    stall = 1;
    s0 = nstarts;
    post(1);
    for (int i = 0; i < 200 && nstarts == s0; i++) @(negedge clk);
    post(2); post(3); post(4); post(6); post(7);
    chk(stat_rdata[30:28] == 4, "R3 full count", stat_rdata[30:28], 4);
    chk(!irq, "R9 irq low empty", irq, 0);
    stall = 0;
    wait_res(4);
    idle(300);
    chk(nstarts - s0 == 5, "R3 dropped write", nstarts - s0, 5);
    chk(stat_rdata[26:24] == 4 && stat_rdata[30:28] == 0, "R4 full keep", stat_rdata[26:24], 4);
    chk(irq, "R9 irq above th", irq, 1);
    pop(st);
    chk(st[18:16] == 1, "R3 order 0", st[18:16], 1);
    chk(!irq, "R9 irq at th", irq, 0);
    wr_cfg(16'h0101);
    chk(!irq, "R9 irq disabled", irq, 0);
    wr_cfg(16'h0109);
    chk(irq, "R9 irq th0", irq, 1);
    for (int i = 0; i < 3; i++) begin
      pop(st);
      chk(st[18:16] == 3'(i + 2), "R3 order", st[18:16], i + 2);
    end
    chk(stat_rdata[26:24] == 0 && !irq, "R4 drained", stat_rdata[26:24], 0);

    // R11
    wr_cfg(16'h0103);
    post(2);
    wait_res(1);
    chk(adc_pd, "R11 pd after conv", adc_pd, 1);
    pop(st);
    s0 = nstarts;
    post(3);
    for (int i = 0; i < 200 && nstarts == s0; i++) @(negedge clk);
    chk(!adc_pd, "R11 pd cleared", adc_pd, 0);
    wait_res(1);
    idle(5);
    chk(adc_pd, "R11 pd again", adc_pd, 1);
    pop(st);

    // R5, R6, R8: continuous mode timing sweep
    for (int di = 0; di < 3; di++) begin
      for (int yi = 0; yi < 3; yi++) begin
        int dv, dl, p;
        logic [2:0] a, b;
        dv = (di == 2) ? 3 : di;
        dl = (yi == 0) ? 0 : (yi == 1 ? 2 : 5);
        p = (dv + 1) * 2;
        a = 3'(di * 3 + yi + 1);
        b = a + 3'd3;
        wr_cfg(16'((dv << 12) | (dl << 8)));
        post(a);
        wait_start(t0); wait_start(t0); wait_start(t0);
        wait_start(t0);
        start_post(b, t1);
        gap = t1 - t0;
        chk(gap > 0 && gap % p == 0, "R5 tick spacing", gap, p);
        wait_start(t2);
        chk(adc_sel == b, "R6 new sel", adc_sel, b);
        chk(t2 - t1 == gap + dl * p, "R6 settle gap", t2 - t1, gap + dl * p);
        start_post(b, t3);
        wait_start(t4);
        chk(t3 - t2 == gap, "R8 repeat gap", t3 - t2, gap);
        chk(t4 - t3 == gap, "R6 same chan no delay", t4 - t3, gap);
      end
    end
    s0 = nstarts;
    idle(200);
    chk(nstarts > s0 + 3, "R8 keeps converting", nstarts - s0, 4);
    chk(stat_rdata[26:24] == 4, "R8 full count", stat_rdata[26:24], 4);
    chk(!adc_pd, "R11 no pd continuous", adc_pd, 0);
    wr_cfg(16'h0101);
    idle(200);
    s0 = nstarts;
    idle(200);
    chk(nstarts == s0, "R7 stops in single", nstarts - s0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule